// File: doc/BRIEF.md
# Host controller command and interrupt register block

This block holds the command, control and interrupt register logic of a USB host controller of the open host controller kind. It sits on a plain 32-bit register bus with a single-cycle write strobe and a combinational read path. Hardware event inputs set sticky interrupt status bits. Software clears them by writing ones. One interrupt line leaves the block, gated by a per-event enable and a master enable.

The block also keeps the control-list-filled flag. Software and the list-processing engine share this flag as a handshake. Software raises it when it queues work. The engine drops it when a pass begins and raises it again whenever it meets a transfer descriptor.

A self-clearing software reset command runs for a fixed number of cycles. While it runs, host bus master access is blocked. It puts the functional state into suspend and returns the operational registers to their reset values, except the interrupt routing bit. It has no effect on anything outside this block.

Top module: `hc_cmdirq_regs`

## Requirements
- R1: An event input that is high at a clock edge sets its interrupt status bit. Event bit k maps to status bit k, and the ownership-change input maps to bit 30. The status register is at offset 0x0C. A set bit stays set until software clears it or a software reset runs.
- R2: A write to offset 0x0C clears each status bit whose written data bit is 1. Written 0 bits leave the status unchanged. A write can never set a status bit.
- R3: When an event and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R4: In the status register at 0x0C, bits 29 down to the event count, and bit 31, always read 0. In the enable register at 0x10, bits 29 down to the event count always read 0.
- R5: The interrupt output is high only when some status bit is set, its enable bit at offset 0x10 is set, and the master enable (bit 31 of 0x10) is set. With the registered option selected, the output follows this condition one cycle later.
- R6: Writing 1 to bit 1 of the command register (0x08) sets the list-filled flag. Writing 0 to that bit leaves the flag unchanged. The flag reads back at bit 1 of 0x08 and drives the flag output.
- R7: A pass-start pulse clears the list-filled flag, and a descriptor-found pulse sets it. A software set in the same cycle as a pass start leaves the flag set.
- R8: Writing 1 to bit 0 of 0x08 starts a software reset. For exactly RST_CYC cycles after that write, bit 0 of 0x08 reads 1 and the bus-block output is high. Both then clear by themselves.
- R9: A software reset sets the functional state (bits 1:0 of 0x00) to suspend, encoded 2'b11. It clears the status bits, the enable bits and the list-filled flag. The routing bit (bit 4 of 0x00) keeps its value.
- R10: While a software reset runs, register writes and event inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset for both reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_i | input | EVT_W | Hardware event pulses |
| own_evt_i | input | 1 | Ownership-change event |
| pass_start_i | input | 1 | Engine starts a control-list pass |
| td_found_i | input | 1 | Engine found a transfer descriptor |
| clf_o | output | 1 | Control-list-filled flag |
| irq_o | output | 1 | Interrupt request |
| hbm_block_o | output | 1 | Blocks host bus master access during reset |
| fstate_o | output | 2 | Functional state |
| route_o | output | 1 | Interrupt routing bit |

## Verification
The bench builds the block with seven event bits, a five-cycle software reset and the registered interrupt output. The short reset window lets a test start several resets, cover the busy period from start to end, and try writes and events in the middle of it. Seven event bits leave a gap of reserved bits above the events, so the read-as-zero rule is tested where it is most likely to break. The registered interrupt option exercises the one-cycle lag of the interrupt line against the reference model.

// File: rtl/hc_regs_pkg.sv
package hc_regs_pkg;
   localparam int DATA_W = 32;

   typedef enum logic [1:0] {
      FS_RESET   = 2'b00,
      FS_RESUME  = 2'b01,
      FS_OPER    = 2'b10,
      FS_SUSPEND = 2'b11
   } fstate_e;

   localparam logic [7:0] OFS_CTRL  = 8'h00;
   localparam logic [7:0] OFS_CMD   = 8'h08;
   localparam logic [7:0] OFS_ISTAT = 8'h0C;
   localparam logic [7:0] OFS_IEN   = 8'h10;

   localparam int SRST_BIT  = 0;
   localparam int CLF_BIT   = 1;
   localparam int ROUTE_BIT = 4;
   localparam int OWN_BIT   = 30;
   localparam int MIE_BIT   = 31;
endpackage

// File: rtl/hc_evt_bank.sv
module hc_evt_bank #(
   parameter int EW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic [EW-1:0] evt_i,
   input  logic [EW-1:0] w1c_i,
   input  logic          en_wr_i,
   input  logic [EW-1:0] en_wdata_i,
   input  logic          mie_wdata_i,
   output logic [EW-1:0] stat_o,
   output logic [EW-1:0] en_o,
   output logic          mie_o,
   output logic          pend_o
);
   logic [EW-1:0] stat_q;
   logic [EW-1:0] en_q;
   logic          mie_q;

   for (genvar i = 0; i < EW; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat_q[i] <= 1'b0;
         end else if (clr_i) begin
            stat_q[i] <= 1'b0;
         end else if (evt_i[i]) begin
            stat_q[i] <= 1'b1;
         end else if (w1c_i[i]) begin
            stat_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         mie_q <= 1'b0;
      end else if (clr_i) begin
         en_q  <= '0;
         mie_q <= 1'b0;
      end else if (en_wr_i) begin
         en_q  <= en_wdata_i;
         mie_q <= mie_wdata_i;
      end
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign mie_o  = mie_q;
   assign pend_o = mie_q & (|(stat_q & en_q));
endmodule

// File: rtl/hc_list_flag.sv
module hc_list_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic sw_set_i,
   input  logic pass_start_i,
   input  logic td_found_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end else if (sw_set_i || td_found_i) begin
         flag_q <= 1'b1;
      end else if (pass_start_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/hc_srst_seq.sv
module hc_srst_seq #(
   parameter int RST_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic busy_o,
   output logic clr_o
);
   localparam int CNT_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYC - 1);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic             start;

   assign start = req_i & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign clr_o  = start | busy_q;
endmodule

// File: rtl/hc_cmdirq_regs.sv
module hc_cmdirq_regs
   import hc_regs_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int EVT_W   = 7,
   parameter int RST_CYC = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   input  logic [EVT_W-1:0]  evt_i,
   input  logic              own_evt_i,
   input  logic              pass_start_i,
   input  logic              td_found_i,
   output logic              clf_o,
   output logic              irq_o,
   output logic              hbm_block_o,
   output logic [1:0]        fstate_o,
   output logic              route_o
);
   localparam int EW = EVT_W + 1;

   if (EVT_W < 1 || EVT_W > 8) begin : g_bad_evt
      $error("EVT_W must be 1..8");
   end
   if (RST_CYC < 1 || RST_CYC > 1000) begin : g_bad_rst
      $error("RST_CYC must be 1..1000 to finish within the reset time limit");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x10");
   end

   logic          sel_ctrl, sel_cmd, sel_istat, sel_ien;
   logic          busy, clr, wr_ok, srst_req, sw_set_clf;
   logic [EW-1:0] evt_all, w1c, stat, en;
   logic          mie, pend, flag;
   fstate_e       fstate_q;
   logic          route_q;

   assign sel_ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
   assign sel_cmd   = (addr_i == ADDR_W'(OFS_CMD));
   assign sel_istat = (addr_i == ADDR_W'(OFS_ISTAT));
   assign sel_ien   = (addr_i == ADDR_W'(OFS_IEN));

   assign wr_ok      = wr_en_i & ~busy;
   assign srst_req   = wr_ok & sel_cmd & wdata_i[SRST_BIT];
   assign sw_set_clf = wr_ok & sel_cmd & wdata_i[CLF_BIT];

   assign evt_all = {own_evt_i, evt_i};
   assign w1c     = (wr_ok & sel_istat) ? {wdata_i[OWN_BIT], wdata_i[EVT_W-1:0]} : '0;

   hc_srst_seq #(.RST_CYC(RST_CYC)) u_srst (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (srst_req),
      .busy_o (busy),
      .clr_o  (clr)
   );

   hc_evt_bank #(.EW(EW)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (clr),
      .evt_i       (evt_all),
      .w1c_i       (w1c),
      .en_wr_i     (wr_ok & sel_ien),
      .en_wdata_i  ({wdata_i[OWN_BIT], wdata_i[EVT_W-1:0]}),
      .mie_wdata_i (wdata_i[MIE_BIT]),
      .stat_o      (stat),
      .en_o        (en),
      .mie_o       (mie),
      .pend_o      (pend)
   );

   hc_list_flag u_clf (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (clr),
      .sw_set_i     (sw_set_clf),
      .pass_start_i (pass_start_i),
      .td_found_i   (td_found_i),
      .flag_o       (flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fstate_q <= FS_RESET;
         route_q  <= 1'b0;
      end else if (clr) begin
         fstate_q <= FS_SUSPEND;
      end else if (wr_ok && sel_ctrl) begin
         fstate_q <= fstate_e'(wdata_i[1:0]);
         route_q  <= wdata_i[ROUTE_BIT];
      end
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = pend;
   end

   always_comb begin
      rdata_o = '0;
      if (sel_ctrl) begin
         rdata_o[1:0]       = fstate_q;
         rdata_o[ROUTE_BIT] = route_q;
      end
      if (sel_cmd) begin
         rdata_o[SRST_BIT] = busy;
         rdata_o[CLF_BIT]  = flag;
      end
      if (sel_istat) begin
         rdata_o[EVT_W-1:0] = stat[EVT_W-1:0];
         rdata_o[OWN_BIT]   = stat[EW-1];
      end
      if (sel_ien) begin
         rdata_o[EVT_W-1:0] = en[EVT_W-1:0];
         rdata_o[OWN_BIT]   = en[EW-1];
         rdata_o[MIE_BIT]   = mie;
      end
   end

   assign clf_o       = flag;
   assign hbm_block_o = busy;
   assign fstate_o    = fstate_q;
   assign route_o     = route_q;
endmodule

// File: rtl/hc_cmdirq_regs_chk.sv
module hc_cmdirq_regs_chk #(
   parameter int EW      = 8,
   parameter int RST_CYC = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic [EW-1:0] evt_all,
   input logic [EW-1:0] stat,
   input logic          mie,
   input logic          flag,
   input logic          sw_set_clf,
   input logic          busy,
   input logic          clr,
   input logic          irq_o,
   input logic          hbm_block_o,
   input logic [1:0]    fstate_o,
   input logic          route_o
);
   int run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= 0;
      else if (busy) run_len <= run_len + 1;
      else           run_len <= 0;
   end

   assert_no_sw_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & ~$past(stat) & ~$past(evt_all)) == '0));

   assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && $past(evt_all) != '0) |-> ((stat & $past(evt_all)) == $past(evt_all)));

   if (IRQ_REG) begin : g_irq_r
      assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> $past(mie));
   end else begin : g_irq_c
      assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> mie);
   end

   assert_sw_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sw_set_clf) && !$past(clr)) |-> flag);

   assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> hbm_block_o);

   assert_reset_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == RST_CYC));

   assert_reset_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (stat == '0 && !flag && fstate_o == 2'b11 && route_o == $past(route_o)));
endmodule

bind hc_cmdirq_regs hc_cmdirq_regs_chk #(
   .EW(EW), .RST_CYC(RST_CYC), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_all     (evt_all),
   .stat        (stat),
   .mie         (mie),
   .flag        (flag),
   .sw_set_clf  (sw_set_clf),
   .busy        (busy),
   .clr         (clr),
   .irq_o       (irq_o),
   .hbm_block_o (hbm_block_o),
   .fstate_o    (fstate_o),
   .route_o     (route_o)
);

// File: tb/hc_cmdirq_regs_bench.sv
module hc_cmdirq_regs_bench;
   localparam int EVT_W   = 7;
   localparam int RST_CYC = 5;
   localparam logic [31:0] STMASK = 32'h4000_0000 | ((32'd1 << EVT_W) - 1);
   localparam logic [31:0] ENMASK = STMASK | 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [EVT_W-1:0] evt = '0;
   logic        own_evt = 1'b0;
   logic        pass_start = 1'b0;
   logic        td_found = 1'b0;
   logic        clf, irq, hbm_block, route;
   logic [1:0]  fstate;

   always #5 clk = ~clk;

   hc_cmdirq_regs #(.ADDR_W(8), .EVT_W(EVT_W), .RST_CYC(RST_CYC), .IRQ_REG(1'b1)) u_hc_cmdirq_regs (
      .clk (clk), .rst_n (rst_n), .wr_en_i (wr_en), .addr_i (addr), .wdata_i (wdata),
      .rdata_o (rdata), .evt_i (evt), .own_evt_i (own_evt), .pass_start_i (pass_start),
      .td_found_i (td_found), .clf_o (clf), .irq_o (irq), .hbm_block_o (hbm_block),
      .fstate_o (fstate), .route_o (route)
   );

   // reference model
   logic [31:0] m_st, m_en;
   logic        m_clf, m_busy, m_irq, m_route;
   logic [1:0]  m_state;
   int          m_cnt;

   always @(posedge clk) begin
      logic [31:0] ev;
      logic req, clr, wok;
      if (!rst_n) begin
         m_st = 0; m_en = 0; m_clf = 0; m_busy = 0; m_irq = 0;
         m_route = 0; m_state = 2'b00; m_cnt = 0;
      end else begin
         ev  = {1'b0, own_evt, 23'd0, 32'(evt)} & STMASK;
         ev  = 32'(evt) | (own_evt ? 32'h4000_0000 : 32'h0);
         wok = wr_en && !m_busy;
         req = wok && addr == 8'h08 && wdata[0];
         clr = req || m_busy;
         m_irq = m_en[31] && ((m_st & m_en & STMASK) != 0);
         if (clr) begin
            m_st = 0; m_en = 0; m_clf = 0; m_state = 2'b11;
         end else begin
            if (wok && addr == 8'h0C) m_st = m_st & ~(wdata & STMASK);
            m_st = m_st | ev;
            if (wok && addr == 8'h10) m_en = wdata & ENMASK;
            if ((wok && addr == 8'h08 && wdata[1]) || td_found) m_clf = 1;
            else if (pass_start) m_clf = 0;
            if (wok && addr == 8'h00) begin
               m_state = wdata[1:0]; m_route = wdata[4];
            end
         end
         if (req) begin
            m_busy = 1; m_cnt = RST_CYC - 1;
         end else if (m_busy) begin
            if (m_cnt == 0) m_busy = 0;
            else m_cnt = m_cnt - 1;
         end
      end
   end

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R9";
   bit    done = 1'b0;

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      logic [31:0] r;
      r = 0;
      case (a)
         8'h00: begin r[1:0] = m_state; r[4] = m_route; end
         8'h08: begin r[0] = m_busy; r[1] = m_clf; end
         8'h0C: r = m_st;
         8'h10: r = m_en;
         default: r = 0;
      endcase
      return r;
   endfunction

   task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      cmp("rdata", rdata, exp_rd(addr));
      cmp("irq", 32'(irq), 32'(m_irq));
      cmp("clf", 32'(clf), 32'(m_clf));
      cmp("block", 32'(hbm_block), 32'(m_busy));
      cmp("state", 32'(fstate), 32'(m_state));
      cmp("route", 32'(route), 32'(m_route));
      wr_en = 0; evt = '0; own_evt = 0; pass_start = 0; td_found = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1; addr = a; wdata = d; cyc();
   endtask

   task automatic rd(input logic [7:0] a);
      addr = a; cyc();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R9"; rd(8'h00); rd(8'h0C);
      // R1 sticky set
      cur_req = "R1";
      addr = 8'h0C; evt = 7'b0000101; cyc();
      rd(8'h0C); rd(8'h0C);
      own_evt = 1; cyc(); rd(8'h0C);
      // R2 write-one-to-clear, zeros ignored, no set by software
      cur_req = "R2";
      wr(8'h0C, 32'h0000_0001); rd(8'h0C);
      wr(8'h0C, 32'h0000_0000); rd(8'h0C);
      wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C);
      wr(8'h0C, 32'h0000_0078); rd(8'h0C);
      // R3 same-cycle set and clear
      cur_req = "R3";
      evt = 7'b0000010; wr(8'h0C, 32'h0000_0002); rd(8'h0C);
      // R4 reserved bits
      cur_req = "R4";
      evt = 7'h7F; own_evt = 1; cyc(); rd(8'h0C);
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
      // R5 interrupt gating
      cur_req = "R5";
      wr(8'h10, 32'h0000_0001); rd(8'h0C); rd(8'h0C);
      wr(8'h10, 32'h8000_0000); rd(8'h0C); rd(8'h0C);
      wr(8'h10, 32'h8000_0004); rd(8'h0C); rd(8'h0C);
      wr(8'h0C, 32'h4000_007F); rd(8'h0C); rd(8'h0C);
      evt = 7'b0000100; cyc(); rd(8'h0C); rd(8'h0C);
      // R6 list-filled set by software
      cur_req = "R6";
      wr(8'h08, 32'h0000_0000); rd(8'h08);
      wr(8'h08, 32'h0000_0002); rd(8'h08);
      // R7 engine handshake
      cur_req = "R7";
      addr = 8'h08; pass_start = 1; cyc(); rd(8'h08);
      pass_start = 1; cyc();
      td_found = 1; cyc(); rd(8'h08);
      pass_start = 1; wr(8'h08, 32'h0000_0002); rd(8'h08);
      pass_start = 1; td_found = 1; cyc(); rd(8'h08);
      // R8/R9/R10 software reset
      cur_req = "R9";
      wr(8'h00, 32'h0000_0012); rd(8'h00);
      wr(8'h10, 32'hC000_00FF); evt = 7'h33; cyc();
      cur_req = "R8";
      wr(8'h08, 32'h0000_0001);
      cur_req = "R10";
      wr(8'h00, 32'h0000_0002);
      evt = 7'h7F; own_evt = 1; wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h08, 32'h0000_0002);
      cur_req = "R8";
      for (int i = 0; i < RST_CYC + 2; i++) rd(8'h08);
      cur_req = "R9";
      rd(8'h00); rd(8'h0C); rd(8'h10);
      cur_req = "R8";
      wr(8'h00, 32'h0000_0001); wr(8'h08, 32'h0000_0003);
      for (int i = 0; i < RST_CYC + 2; i++) rd(8'h08);
      cur_req = "R9";
      rd(8'h00); rd(8'h0C);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule